// File: doc/BRIEF.md
# Relocatable Memory Map Decoder with Overlap Priority

This block sits on the 16-bit address bus of a small microcontroller and decides, for every CPU address, which on-chip target answers. Four internal targets can be placed in the address space: a 1 KB register block, a 12 KB RAM, a 4 KB EEPROM and a paged flash array. Each movable target has a small placement register. When placements overlap, a fixed priority chain picks the winner. Any address that no internal target claims goes to the external bus. A debug request input takes precedence over everything else and stands in for a debug firmware space.

The decode is purely combinational from the address and the current register values. The outputs are a one-hot select vector, an offset local to the chosen target and, for flash, a flat address formed from a page number and the 14-bit in-page offset. The flash page is fixed at 0x3E in 0x4000–0x7FFF and at 0x3F in 0xC000–0xFFFF. In 0x8000–0xBFFF it comes from a writable page register, so page 0x3E can also be reached through that window.

Top module: `mmap_decode`

## Requirements
- R1: After reset the register block claims 0x0000–0x03FF, the RAM claims 0x1000–0x3FFF, the EEPROM is enabled at 0x0000 (visible from 0x0400 to 0x0FFF) and the page register holds 0x00.
- R2: Overlaps resolve in this order, strongest first: debug request, register block, RAM, EEPROM, flash, external. While `dbg_req` is high, select bit 5 is the only one set.
- R3: For every address exactly one bit of `tgt_sel` is high. The bits are 5 debug, 4 register block, 3 RAM, 2 EEPROM, 1 flash and 0 external.
- R4: A write with `wr_idx`=0 sets the register block base. `wr_data[7:2]` becomes address bits 15:10, so the block is aligned to 1 KB. Its local offset is address bits 9:0.
- R5: A write with `wr_idx`=1 sets the RAM window. `wr_data[7:6]` gives address bits 15:14 of a 16 KB window. The RAM claims only the upper 12 KB of that window, and its lowest 4 KB falls through to lower targets. The RAM offset is the in-window offset minus 0x1000.
- R6: A write with `wr_idx`=2 sets the EEPROM placement. `wr_data[7:4]` gives address bits 15:12 and `wr_data[0]` enables it. A disabled EEPROM claims nothing. The EEPROM offset is address bits 11:0.
- R7: Flash claims 0x4000–0xFFFF. The page is 0x3E below 0x8000, the page register from 0x8000 to 0xBFFF, and 0x3F from 0xC000 up. `flash_addr` = page × 0x4000 + address bits 13:0, and the flash offset is address bits 13:0.
- R8: Addresses claimed by no internal target select external, with `local_off` equal to the address. The debug target also passes the address through unchanged.
- R9: A write with `wr_idx`=3 loads the page register. Every register write alters decoding from the clock edge that captures it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the placement registers |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index: 0 register block, 1 RAM, 2 EEPROM, 3 page |
| wr_data | input | 8 | Write data |
| dbg_req | input | 1 | Debug space claims the current access |
| cpu_addr | input | 16 | CPU address |
| tgt_sel | output | 6 | One-hot target select |
| local_off | output | 16 | Offset within the selected target |
| flash_addr | output | 22 | Flat paged flash address |

## Verification
A wrong placement register shows up at the ports in the same cycle as the first address that reaches the moved region. That address selects the wrong target, or it selects the right target with a shifted offset. A page register error shows up only in the 0x8000–0xBFFF window, as a wrong upper part of `flash_addr`. The bench therefore combines random addresses after each random register write with directed probes at region edges and at overlaps. A stale or early register update is then caught on the first access to the affected range after the write edge.

// File: rtl/mmap_decode.sv
module mmap_decode #(
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] FIX_LO_PAGE = 8'h3E,
  parameter logic [PAGE_W-1:0] FIX_HI_PAGE = 8'h3F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_idx,
  input  logic [7:0]           wr_data,
  input  logic                 dbg_req,
  input  logic [15:0]          cpu_addr,
  output logic [5:0]           tgt_sel,
  output logic [15:0]          local_off,
  output logic [PAGE_W+13:0]   flash_addr
);
  localparam int S_DBG = 5, S_REG = 4, S_RAM = 3, S_EEP = 2, S_FL = 1, S_EXT = 0;

  logic [5:0]        reg_base_q;
  logic [1:0]        ram_win_q;
  logic [3:0]        eep_base_q;
  logic              eep_en_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_base_q <= '0;
      ram_win_q  <= '0;
      eep_base_q <= '0;
      eep_en_q   <= 1'b1;
      page_q     <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        2'd0: reg_base_q <= wr_data[7:2];
        2'd1: ram_win_q  <= wr_data[7:6];
        2'd2: begin
          eep_base_q <= wr_data[7:4];
          eep_en_q   <= wr_data[0];
        end
        default: page_q <= PAGE_W'(wr_data);
      endcase
    end
  end

  wire hit_reg = cpu_addr[15:10] == reg_base_q;
  wire hit_ram = (cpu_addr[15:14] == ram_win_q) && (cpu_addr[13:12] != 2'b00);
  wire hit_eep = eep_en_q && (cpu_addr[15:12] == eep_base_q);
  wire hit_fl  = cpu_addr[15:14] != 2'b00;

  logic [PAGE_W-1:0] page;
  always_comb begin
    case (cpu_addr[15:14])
      2'b01:   page = FIX_LO_PAGE;
      2'b10:   page = page_q;
      2'b11:   page = FIX_HI_PAGE;
      default: page = '0;
    endcase
  end
  assign flash_addr = {page, cpu_addr[13:0]};

  always_comb begin
    tgt_sel   = '0;
    local_off = cpu_addr;
    if (dbg_req) begin
      tgt_sel[S_DBG] = 1'b1;
    end else if (hit_reg) begin
      tgt_sel[S_REG] = 1'b1;
      local_off      = {6'd0, cpu_addr[9:0]};
    end else if (hit_ram) begin
      tgt_sel[S_RAM] = 1'b1;
      local_off      = {2'b00, cpu_addr[13:0] - 14'h1000};
    end else if (hit_eep) begin
      tgt_sel[S_EEP] = 1'b1;
      local_off      = {4'd0, cpu_addr[11:0]};
    end else if (hit_fl) begin
      tgt_sel[S_FL]  = 1'b1;
      local_off      = {2'b00, cpu_addr[13:0]};
    end else begin
      tgt_sel[S_EXT] = 1'b1;
    end
  end
endmodule

// File: rtl/mmap_decode_chk.sv
module mmap_decode_chk #(
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] FIX_HI_PAGE = 8'h3F
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_idx,
  input logic [7:0]          wr_data,
  input logic                dbg_req,
  input logic [15:0]         cpu_addr,
  input logic [5:0]          tgt_sel,
  input logic [15:0]         local_off,
  input logic [PAGE_W+13:0]  flash_addr,
  input logic [PAGE_W-1:0]   page_q
);
  // R3
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tgt_sel) == 1);

  // R2
  dbg_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> tgt_sel == 6'b100000);

  // R7
  hi_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel[1] && cpu_addr[15:14] == 2'b11) |-> flash_addr[PAGE_W+13:14] == FIX_HI_PAGE);

  // R8
  ext_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[0] |-> (local_off == cpu_addr && cpu_addr[15:14] == 2'b00));

  // R4
  reg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[4] |-> local_off[15:10] == 6'd0);

  // R9
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2'd3) |=> page_q == PAGE_W'($past(wr_data)));
endmodule

bind mmap_decode mmap_decode_chk #(.PAGE_W(PAGE_W), .FIX_HI_PAGE(FIX_HI_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .dbg_req(dbg_req), .cpu_addr(cpu_addr), .tgt_sel(tgt_sel),
  .local_off(local_off), .flash_addr(flash_addr), .page_q(page_q)
);

// File: tb/sim_mmap_decode.sv
module sim_mmap_decode;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic        dbg_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [5:0]  tgt_sel;
  logic [15:0] local_off;
  logic [21:0] flash_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] m_reg = 8'h00, m_ram = 8'h00, m_eep = 8'h01, m_pg = 8'h00;

  mmap_decode u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .dbg_req(dbg_req), .cpu_addr(cpu_addr),
    .tgt_sel(tgt_sel), .local_off(local_off), .flash_addr(flash_addr));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [5:0] exp_sel(input logic [15:0] a, input logic d);
    if (d) return 6'b100000;
    if (a[15:10] == m_reg[7:2]) return 6'b010000;
    if (a[15:14] == m_ram[7:6] && a[13:0] >= 14'h1000) return 6'b001000;
    if (m_eep[0] && a[15:12] == m_eep[7:4]) return 6'b000100;
    if (a >= 16'h4000) return 6'b000010;
    return 6'b000001;
  endfunction

  function automatic logic [15:0] exp_off(input logic [15:0] a, input logic [5:0] s);
    case (s)
      6'b010000: return a % 16'h0400;
      6'b001000: return (a % 16'h4000) - 16'h1000;
      6'b000100: return a % 16'h1000;
      6'b000010: return a % 16'h4000;
      default:   return a;
    endcase
  endfunction

  function automatic logic [21:0] exp_flat(input logic [15:0] a);
    logic [7:0] p;
    if (a < 16'h8000) p = 8'h3E;
    else if (a < 16'hC000) p = m_pg;
    else p = 8'h3F;
    return 22'(p) * 22'h4000 + 22'(a % 16'h4000);
  endfunction

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    case (idx)
      2'd0: m_reg = d;
      2'd1: m_ram = d;
      2'd2: m_eep = d;
      default: m_pg = d;
    endcase
  endtask

  task automatic probe(input logic [15:0] a, input logic d, input string rq);
    logic [5:0] es;
    @(negedge clk);
    cpu_addr = a; dbg_req = d;
    #1;
    es = exp_sel(a, d);
    n_chk++;
    if (tgt_sel !== es) begin
      n_bad++;
      $display("FAIL %s sel addr=%h got=%b exp=%b", rq, a, tgt_sel, es);
    end
    n_chk++;
    if (local_off !== exp_off(a, es)) begin
      n_bad++;
      $display("FAIL %s off addr=%h got=%h exp=%h", rq, a, local_off, exp_off(a, es));
    end
    if (es == 6'b000010) begin
      n_chk++;
      if (flash_addr !== exp_flat(a)) begin
        n_bad++;
        $display("FAIL %s flat addr=%h got=%h exp=%h", rq, a, flash_addr, exp_flat(a));
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=timeout exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset placement
    probe(16'h0000, 0, "R1"); probe(16'h03FF, 0, "R1");
    probe(16'h0400, 0, "R1"); probe(16'h0FFF, 0, "R1");
    probe(16'h1000, 0, "R1"); probe(16'h3FFF, 0, "R1");
    // R7 fixed pages and window at page 0
    probe(16'h4000, 0, "R7"); probe(16'hC123, 0, "R7"); probe(16'h8001, 0, "R7");
    // R2 debug over registers
    probe(16'h0000, 1, "R2"); probe(16'h9ABC, 1, "R10");
    // R6 / R9: EEPROM over fixed flash, visible only after the write edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd2; wr_data = 8'h41; cpu_addr = 16'h4010; dbg_req = 1'b0;
    #1 n_chk++;
    if (tgt_sel !== 6'b000010) begin
      n_bad++; $display("FAIL R9 early got=%b exp=%b", tgt_sel, 6'b000010);
    end
    @(posedge clk); #1 wr_en = 1'b0; m_eep = 8'h41;
    probe(16'h4010, 0, "R9"); probe(16'h4FFF, 0, "R6"); probe(16'h5000, 0, "R6");
    // R2 RAM beats EEPROM
    wr(2'd2, 8'h11);
    probe(16'h1000, 0, "R2"); probe(16'h1FFF, 0, "R2");
    // R5 move RAM; bottom 4 KB of its window falls through
    wr(2'd1, 8'h40);
    probe(16'h4000, 0, "R5"); probe(16'h4FFF, 0, "R5");
    probe(16'h5000, 0, "R5"); probe(16'h7FFF, 0, "R5");
    probe(16'h1000, 0, "R5");
    // R6 disabled EEPROM, R8 external
    wr(2'd2, 8'h10);
    probe(16'h1000, 0, "R6"); probe(16'h2222, 0, "R8");
    // R7 page register reaches fixed page through window
    wr(2'd3, 8'h3E);
    probe(16'h8123, 0, "R7"); probe(16'hBFFF, 0, "R7");
    // R4 move register block
    wr(2'd0, 8'h04);
    probe(16'h0400, 0, "R4"); probe(16'h07FF, 0, "R4"); probe(16'h0000, 0, "R4");
    wr(2'd0, 8'h50);
    probe(16'h5000, 0, "R4"); probe(16'h53FF, 0, "R4");
    // R3 random mix
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 8) == 0) wr(2'($urandom % 4), 8'($urandom));
      probe(16'($urandom), (($urandom % 16) == 0), "R3");
    end
    finish_run();
  end
endmodule